// File: doc/BRIEF.md
# Palette Load Controller

This block copies a full colour palette from video memory into a palette RAM. It watches for a write to the texture-configuration register. The register's fields arrive already decoded: a base pointer, an entry format, a storage mode, a start offset and a load-control code. When those fields ask for a supported load, the block walks 256 consecutive 32-bit words, starting at byte `base * 256` of a byte-addressed memory read port. Each word is forwarded unchanged to the palette write port at its own index.

Only one case is supported: 32-bit entries, linear storage, unconditional loading and a zero start offset. Every other combination is refused outright. In that case the block stays idle and the palette is not written. A configuration write that arrives during a copy is dropped, and the copy that is running always completes.

Top module: `palette_load_ctrl`

## Requirements
- R1: A copy starts on the clock edge that samples `cfg_wr` high when the block is idle, `cfg_ctrl` is 1, `cfg_fmt` is 0 (32-bit entries), `cfg_linear` is 1 and `cfg_offset` is 0.
- R2: A write with `cfg_linear` = 0 starts no copy, even when all other fields request one: `busy` stays low and `pal_we` is never asserted.
- R3: A write with `cfg_ctrl` equal to 0 or to 2 through 7, with a non-zero `cfg_fmt`, or with a non-zero `cfg_offset` starts no copy and writes nothing to the palette.
- R4: During a copy, entry i is read from byte address `base*256 + 4*i`, where `base` is the pointer captured at the start, for i = 0 to 255 in ascending order.
- R5: `busy` is high for exactly 256 consecutive cycles per copy, and exactly 256 palette writes occur, with indices 0 through 255 in ascending order.
- R6: The palette write for index i occurs one cycle after its address is presented. `pal_wdata` carries the word that memory returns for that address, unchanged: red in bits 7:0, green in 15:8, blue in 23:16 and alpha in 31:24.
- R7: A configuration write that arrives while `busy` is high is ignored. The running copy keeps its base and finishes all 256 entries.
- R8: When `rst_n` is low at a clock edge, the block returns to idle with `busy` and `pal_we` low, and it issues no further palette writes until a new copy is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | One-cycle configuration write pulse |
| cfg_base | input | 14 | Palette base pointer, in 256-byte units |
| cfg_fmt | input | 4 | Palette entry format; 0 means 32-bit |
| cfg_linear | input | 1 | Storage mode; 1 means linear |
| cfg_offset | input | 5 | Palette start offset |
| cfg_ctrl | input | 3 | Load-control code; 1 means load unconditionally |
| mem_raddr | output | 32 | Byte address to the memory read port |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| pal_we | output | 1 | Palette write enable |
| pal_idx | output | 8 | Palette write index |
| pal_wdata | output | 32 | Palette write data |
| busy | output | 1 | High while a copy is in progress |

## Verification
The bench builds the block with its default parameters: 256 entries of 32 bits, a 14-bit pointer and a 256-byte pointer unit. Copy-length and index-wrap behaviour are therefore exercised at their real sizes. The memory model returns, one cycle late, a word computed from the address. This lets every palette write be matched against the exact address it came from, so off-by-one latency and address-stride faults become visible. Bases of 0, 4 and the largest pointer value cover the low and high ends of the address range.

// File: rtl/palette_load_ctrl.sv
module palette_load_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PTR_W     = 14,
  parameter int FMT_W     = 4,
  parameter int OFS_W     = 5,
  parameter int CTL_W     = 3,
  parameter int ENTRIES   = 256,
  parameter int PTR_SHIFT = 8,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int BYTES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PTR_W-1:0]  cfg_base,
  input  logic [FMT_W-1:0]  cfg_fmt,
  input  logic              cfg_linear,
  input  logic [OFS_W-1:0]  cfg_offset,
  input  logic [CTL_W-1:0]  cfg_ctrl,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pal_we,
  output logic [IDX_W-1:0]  pal_idx,
  output logic [DATA_W-1:0] pal_wdata,
  output logic              busy
);

  logic [PTR_W-1:0] base_q;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             we_q;

  wire start = cfg_wr && !busy_q && (cfg_ctrl == CTL_W'(1)) &&
               (cfg_fmt == '0) && cfg_linear && (cfg_offset == '0);
  wire last  = (cnt_q == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      we_q  <= busy_q;
      idx_q <= cnt_q;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        base_q <= cfg_base;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign mem_raddr = (ADDR_W'(base_q) << PTR_SHIFT) + ADDR_W'(cnt_q) * ADDR_W'(BYTES);
  assign pal_we    = we_q;
  assign pal_idx   = idx_q;
  assign pal_wdata = mem_rdata;
  assign busy      = busy_q;

  logic [IDX_W:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> run_q == (IDX_W+1)'(ENTRIES));

  p_refuse_swizzled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cfg_wr && !cfg_linear) |=> !busy_q);

  p_refuse_modes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cfg_wr && (cfg_ctrl != CTL_W'(1) || cfg_fmt != '0 || cfg_offset != '0))
    |=> !busy_q);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> mem_raddr == $past(mem_raddr) + ADDR_W'(BYTES));

  p_first_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_we) |-> pal_idx == '0);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_we && $past(pal_we)) |-> pal_idx == $past(pal_idx) + 1'b1);

  p_we_lags_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |=> !pal_we);

endmodule

// File: tb/palette_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module palette_load_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_linear;
  logic [13:0] cfg_base;
  logic [3:0] cfg_fmt;
  logic [4:0] cfg_offset;
  logic [2:0] cfg_ctrl;
  logic [31:0] mem_raddr, mem_rdata, pal_wdata;
  logic pal_we, busy;
  logic [7:0] pal_idx;

  always #10 clk = ~clk;

  palette_load_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
    .cfg_fmt(cfg_fmt), .cfg_linear(cfg_linear), .cfg_offset(cfg_offset),
    .cfg_ctrl(cfg_ctrl), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_wdata(pal_wdata), .busy(busy)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[7:0] ^ 8'hA5, a[23:16] + 8'h3C, a[15:8], a[9:2]};
  endfunction

  always_ff @(posedge clk) mem_rdata <= word_at(mem_raddr);

  int errors = 0, checks = 0;
  int busy_cyc, wr_cnt, bad_wr, addr_i, bad_addr;
  logic [31:0] exp_base;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (mem_raddr !== (exp_base << 8) + 32'(addr_i) * 4) bad_addr++;
        addr_i++;
        busy_cyc++;
      end
      if (pal_we) begin
        if (pal_idx !== 8'(wr_cnt) ||
            pal_wdata !== word_at((exp_base << 8) + 32'(wr_cnt) * 4)) bad_wr++;
        wr_cnt++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon(input logic [13:0] b);
    exp_base = 32'(b);
    busy_cyc = 0; wr_cnt = 0; bad_wr = 0; addr_i = 0; bad_addr = 0;
  endtask

  task automatic pulse(input logic [13:0] b, input logic [3:0] f, input logic lin,
                       input logic [4:0] o, input logic [2:0] c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_base = b; cfg_fmt = f; cfg_linear = lin; cfg_offset = o; cfg_ctrl = c;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 reset busy", int'(busy), 0);
    check("R8 reset we", int'(pal_we), 0);
  endtask

  task automatic t_load(input logic [13:0] b);
    clear_mon(b);
    pulse(b, 4'd0, 1'b1, 5'd0, 3'd1);
    repeat (300) @(negedge clk);
    check("R1/R5 busy cycles", busy_cyc, 256);
    check("R5 write count", wr_cnt, 256);
    check("R4 address sequence errors", bad_addr, 0);
    check("R6 write idx/data errors", bad_wr, 0);
  endtask

  task automatic t_refuse(input string req, input logic [3:0] f, input logic lin,
                          input logic [4:0] o, input logic [2:0] c);
    clear_mon(14'd4);
    pulse(14'd4, f, lin, o, c);
    repeat (20) @(negedge clk);
    check(req, busy_cyc + wr_cnt, 0);
  endtask

  task automatic t_busy_ignore();
    clear_mon(14'd7);
    pulse(14'd7, 4'd0, 1'b1, 5'd0, 3'd1);
    repeat (50) @(negedge clk);
    pulse(14'd9, 4'd0, 1'b1, 5'd0, 3'd1);
    repeat (300) @(negedge clk);
    check("R7 busy cycles", busy_cyc, 256);
    check("R7 write count", wr_cnt, 256);
    check("R7 data from first base", bad_wr + bad_addr, 0);
  endtask

  task automatic t_reset_mid();
    clear_mon(14'd2);
    pulse(14'd2, 4'd0, 1'b1, 5'd0, 3'd1);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 busy low in reset", int'(busy), 0);
    check("R8 we low in reset", int'(pal_we), 0);
    rst_n = 1'b1;
    wr_cnt = 0; busy_cyc = 0;
    repeat (20) @(negedge clk);
    check("R8 no activity after reset", busy_cyc + wr_cnt, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_base = '0; cfg_fmt = '0;
    cfg_linear = 1'b0; cfg_offset = '0; cfg_ctrl = '0;
    exp_base = '0;
    clear_mon(14'd0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_load(14'd4);
    t_refuse("R2 linear=0 refused", 4'd0, 1'b0, 5'd0, 3'd1);
    t_refuse("R3 ctrl=2 refused", 4'd0, 1'b1, 5'd0, 3'd2);
    t_refuse("R3 ctrl=7 refused", 4'd0, 1'b1, 5'd0, 3'd7);
    t_refuse("R3 ctrl=0 refused", 4'd0, 1'b1, 5'd0, 3'd0);
    t_refuse("R3 fmt=2 refused", 4'd2, 1'b1, 5'd0, 3'd1);
    t_refuse("R3 offset=3 refused", 4'd0, 1'b1, 5'd3, 3'd1);
    t_load(14'd0);
    t_load(14'h3FFF);
    t_busy_ignore();
    t_reset_mid();
    t_load(14'd4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule